// File: doc/BRIEF.md
# Rotating Round-Constant Sequencer

This block supplies the rotated 32-bit key-schedule constants for the 128-bit-key variant of an add-rotate-xor block cipher. There are four base constants, and cipher round i consumes the constant with index i mod 4, left-rotated by i, i+1, i+2 and i+3 bit positions. No table indexed by round is kept. The four constants sit in a ring of four 32-bit registers. Every hop around the ring also rotates the travelling word left by one bit. The register at the head of the ring therefore always holds the round's first rotated form, and the other forms come from wiring alone.

A build-time parameter selects one of two organisations. In parallel mode (`SERIAL_MODE = 0`), all four rotated forms appear at once on four output ports, and the ring moves once per round on `round_advance`. In serial mode (`SERIAL_MODE = 1`), only `rc0_o` carries data. A round lasts four cycles: the advance loads the head register from its neighbour, and three `step` pulses then rotate the head in place. When the head re-enters the ring it is rotated right by two bits, which undoes the extra in-place rotations. The constants are level outputs with no handshake. The cipher datapath samples them in the cycles it chooses. `start` reloads round 0 at any time, and the controller never raises `round_advance` and `step` in the same cycle.

Top module: `rcs_sequencer`

## Requirements
- R1: After reset, and in the cycle after `start`, the block presents round 0. In parallel mode `rc0_o..rc3_o` hold ROL0..ROL3 of 0xC3EFE9DB. In serial mode `rc0_o` holds 0xC3EFE9DB.
- R2: In parallel mode, after n advances since the last load, `rck_o` equals ROL by (n+k) mod 32 of constant d[n mod 4], where d = {0xC3EFE9DB, 0x44626B02, 0x79E27C8A, 0x78DF30EC} and k is 0 to 3.
- R3: In parallel mode, the outputs keep their values in any cycle where neither `start` nor `round_advance` is high.
- R4: In serial mode, each `step` rotates `rc0_o` left by one bit. After p steps in round i, the output is ROL by (i+p) mod 32 of d[i mod 4].
- R5: In serial mode, an advance that follows exactly three steps shows ROL by i mod 32 of d[i mod 4] for the new round i.
- R6: In serial mode, `rc0_o` holds its value in any cycle with no `start`, `round_advance` or `step`, including cycles in the middle of a round.
- R7: `start` takes priority over `round_advance` and `step` raised in the same cycle, and the block returns to round 0 with step count 0.
- R8: In serial mode, `rc1_o`, `rc2_o` and `rc3_o` are constantly zero.
- R9: In parallel mode, `step` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads round 0 |
| start | input | 1 | Reload the base constants (round 0) |
| round_advance | input | 1 | Move the ring to the next round |
| step | input | 1 | Serial mode: next rotated form within the round |
| rc0_o | output | 32 | Rotated constant, offset 0 (serial: the only output) |
| rc1_o | output | 32 | Rotated constant, offset 1 (serial: zero) |
| rc2_o | output | 32 | Rotated constant, offset 2 (serial: zero) |
| rc3_o | output | 32 | Rotated constant, offset 3 (serial: zero) |

## Verification
The bench builds two copies of the block side by side, one with `SERIAL_MODE = 0` and one with `SERIAL_MODE = 1`, and drives them with the same control stream. The serial copy needs its three steps per round, and the parallel copy receives those same steps, so the check that `step` is ignored in parallel mode comes with no extra stimulus. The run covers 24 rounds and, after a restart, 36 more. Rotation amounts therefore pass 31 and wrap, and every base constant goes around the ring many times. Both the return right-rotation in serial mode and the modulo-32 wrap are exercised.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned RC_W = 32;
  localparam int unsigned RC_N = 4;
  localparam int unsigned RING_BITS = RC_W * RC_N;

  function automatic logic [RC_W-1:0] rc_base(input int unsigned idx);
    case (idx)
      0:       return 32'hC3EF_E9DB;
      1:       return 32'h4462_6B02;
      2:       return 32'h79E2_7C8A;
      3:       return 32'h78DF_30EC;
      default: return '0;
    endcase
  endfunction

  function automatic logic [RC_W-1:0] rc_rol(input logic [RC_W-1:0] x,
                                             input int unsigned n);
    logic [2*RC_W-1:0] wide;
    wide = {x, x} << (n % RC_W);
    return wide[2*RC_W-1:RC_W];
  endfunction

  function automatic int unsigned rc_pop(input logic [RING_BITS-1:0] v);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned b = 0; b < RING_BITS; b++) cnt += v[b];
    return cnt;
  endfunction
endpackage

// File: rtl/rcs_ring.sv
module rcs_ring
  import rcs_pkg::*;
#(
  parameter bit SERIAL = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            hop_i,
  input  logic            spin_i,
  output logic [RC_W-1:0] head_o
);
  localparam int unsigned NSLOT   = RC_N;
  localparam int unsigned RET_ROT = SERIAL ? RC_W - 2 : 1;
  localparam int unsigned WEIGHT  =
    rc_pop({rc_base(3), rc_base(2), rc_base(1), rc_base(0)});

  logic [NSLOT-1:0][RC_W-1:0] slot_q, slot_d;
  logic                        spin_ok;

  assign spin_ok = SERIAL && spin_i;

  always_comb begin
    for (int unsigned k = 0; k < NSLOT; k++) begin
      slot_d[k] = slot_q[k];
      if (load_i) begin
        slot_d[k] = rc_base(k);
      end else if (hop_i) begin
        if (k == NSLOT - 1) slot_d[k] = rc_rol(slot_q[0], RET_ROT);
        else                slot_d[k] = rc_rol(slot_q[k+1], 1);
      end else if (spin_ok && k == 0) begin
        slot_d[k] = rc_rol(slot_q[0], 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned k = 0; k < NSLOT; k++) slot_q[k] <= rc_base(k);
    end else begin
      slot_q <= slot_d;
    end
  end

  assign head_o = slot_q[0];

  // R2 R5: rotations keep the total bit weight of the ring
  ring_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rc_pop(slot_q) == WEIGHT);

  // R3 R6 R9
  ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !hop_i && !spin_ok) |=> $stable(slot_q));

  // R1 R7
  ring_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> head_o == rc_base(0));

  if (SERIAL) begin : g_serial_chk
    logic [1:0] spins_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 spins_q <= '0;
      else if (load_i || hop_i)   spins_q <= '0;
      else if (spin_i)            spins_q <= spins_q + 2'd1;
    end

    // R4
    spin_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spin_i && !load_i && !hop_i) |=> head_o == rc_rol($past(head_o), 1));

    // R4
    spin_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spin_i && !load_i) |-> spins_q != 2'd3);

    // R5
    spin_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hop_i && !load_i) |-> spins_q == 2'd3);
  end

  // R7: controller contract
  ctl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hop_i && spin_i));
endmodule

// File: rtl/rcs_taps.sv
module rcs_taps
  import rcs_pkg::*;
#(
  parameter bit SERIAL = 1'b0
) (
  input  logic [RC_W-1:0]           head_i,
  output logic [RC_N-1:0][RC_W-1:0] tap_o
);
  for (genvar k = 0; k < RC_N; k++) begin : g_tap
    if (k == 0) begin : g_head
      assign tap_o[k] = head_i;
    end else if (SERIAL) begin : g_off
      assign tap_o[k] = '0;
    end else begin : g_wire
      assign tap_o[k] = rc_rol(head_i, k);
    end
  end
endmodule

// File: rtl/rcs_sequencer.sv
module rcs_sequencer
  import rcs_pkg::*;
#(
  parameter bit SERIAL_MODE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            round_advance,
  input  logic            step,
  output logic [RC_W-1:0] rc0_o,
  output logic [RC_W-1:0] rc1_o,
  output logic [RC_W-1:0] rc2_o,
  output logic [RC_W-1:0] rc3_o
);
  logic [RC_W-1:0]           head;
  logic [RC_N-1:0][RC_W-1:0] taps;

  rcs_ring #(.SERIAL(SERIAL_MODE)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start),
    .hop_i  (round_advance),
    .spin_i (step),
    .head_o (head)
  );

  rcs_taps #(.SERIAL(SERIAL_MODE)) u_taps (
    .head_i (head),
    .tap_o  (taps)
  );

  assign rc0_o = taps[0];
  assign rc1_o = taps[1];
  assign rc2_o = taps[2];
  assign rc3_o = taps[3];

  // R8 R9: outputs only move when the ring is told to move
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !round_advance && !(SERIAL_MODE && step))
      |=> $stable({rc3_o, rc2_o, rc1_o, rc0_o}));
endmodule

// File: tb/rcs_sequencer_tb.sv
module rcs_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    string       tag_p;
    string       tag_s;
    logic [31:0] ep [4];
    logic [31:0] es;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, round_advance = 1'b0, step = 1'b0;
  logic [31:0] p0, p1, p2, p3, s0, s1, s2, s3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int rnd = 0;
  int ph = 0;
  item_t sb [$];

  logic [31:0] base [4] = '{32'hC3EFE9DB, 32'h44626B02, 32'h79E27C8A, 32'h78DF30EC};

  always #(CLK_PERIOD/2) clk = ~clk;

  rcs_sequencer #(.SERIAL_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .round_advance(round_advance),
    .step(step), .rc0_o(p0), .rc1_o(p1), .rc2_o(p2), .rc3_o(p3));

  rcs_sequencer #(.SERIAL_MODE(1'b1)) u_dut_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .round_advance(round_advance),
    .step(step), .rc0_o(s0), .rc1_o(s1), .rc2_o(s2), .rc3_o(s3));

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    int s;
    s = n % 32;
    return (x << s) | (x >> ((32 - s) % 32));
  endfunction

  task automatic push(input string tp, input string ts);
    item_t it;
    it.tag_p = tp;
    it.tag_s = ts;
    for (int k = 0; k < 4; k++) it.ep[k] = rol(base[rnd % 4], rnd + k);
    it.es = rol(base[rnd % 4], rnd + ph);
    sb.push_back(it);
  endtask

  task automatic drive(input bit st, input bit adv, input bit stp,
                       input string tp, input string ts);
    @(negedge clk);
    start = st; round_advance = adv; step = stp;
    @(posedge clk);
    #1;
    start = 1'b0; round_advance = 1'b0; step = 1'b0;
    if (st)       begin rnd = 0; ph = 0; end
    else if (adv) begin rnd++; ph = 0; end
    else if (stp) ph++;
    push(tp, ts);
  endtask

  task automatic play_round(input string adv_tag);
    for (int p = 0; p < 3; p++) begin
      drive(0, 0, 1, "R9", "R4");
      if (p == 1 && rnd % 5 == 0) drive(0, 0, 0, "R3", "R6");
    end
    drive(0, 1, 0, adv_tag, "R5");
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if ({p3, p2, p1, p0} !== {it.ep[3], it.ep[2], it.ep[1], it.ep[0]}) begin
        errors++;
        $display("FAIL %s parallel: got %h %h %h %h exp %h %h %h %h", it.tag_p,
                 p0, p1, p2, p3, it.ep[0], it.ep[1], it.ep[2], it.ep[3]);
      end
      checks++;
      if (s0 !== it.es) begin
        errors++;
        $display("FAIL %s serial: got %h exp %h", it.tag_s, s0, it.es);
      end
      checks++;
      if ({s3, s2, s1} !== 96'h0) begin
        errors++;
        $display("FAIL R8 serial unused: got %h %h %h exp 0 0 0", s1, s2, s3);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, then an idle cycle
    drive(0, 0, 0, "R1", "R1");
    // R2 R4 R5 R9: first 24 rounds
    for (int r = 0; r < 24; r++) play_round("R2");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, "R3", "R6");
    // R7: start wins over advance, then over step
    drive(0, 0, 1, "R9", "R4");
    drive(1, 1, 0, "R7", "R7");
    drive(0, 0, 1, "R9", "R4");
    drive(1, 0, 1, "R7", "R7");
    // R2: past the 32-bit rotation wrap
    for (int r = 0; r < 36; r++) play_round("R2");
    drive(1, 0, 0, "R1", "R1");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule